// File: doc/BRIEF.md
# Ones' Complement End-Around-Carry Adder/Subtractor

This block adds or subtracts two n-bit ones' complement numbers in a single combinational path. In ones' complement the negative of a value is its bitwise inverse, so subtraction needs no separate unit. When subtracting, the second operand is inverted and then added.

A two's complement adder throws away the carry that leaves the sign position. This adder instead feeds that carry back in as a +1 at the least significant bit. That fold-back is what makes the modular arithmetic correct for the ones' complement encoding.

Three results leave the block:
- the corrected sum;
- the carry produced by the first addition, exposed for debug;
- an overflow flag.

Zero has two encodings, all zeros and all ones. A build-time parameter decides whether an all-ones result passes through unchanged or is rewritten to all zeros. The block has no clock and no handshake: its outputs follow its inputs in the same evaluation. A surrounding pipeline may register them as it sees fit.

Top module: `oc_eac_adder`

## Requirements
- R1: With `sub_i` = 0 and the true sum inside ±(2^(n−1)−1), `sum_o` holds a+b and `ovf_o` is 0. Here the value of a word x is x when its top bit is 0, and −(~x) when its top bit is 1.
- R2: With `sub_i` = 1, the second operand is inverted bit by bit before the addition. `sum_o` then holds a−b under the same value mapping whenever that difference is in range.
- R3: Before any zero rewrite, the result equals the low n bits of a + b_eff + c, where b_eff is the possibly inverted second operand and c is the raw carry.
- R4: `carry_raw_o` equals bit n of the (n+1)-bit sum a + b_eff.
- R5: `ovf_o` is 1 exactly when a and b_eff share a top bit and the pre-rewrite result has the other top bit. This is exactly the case where the true result lies outside ±(2^(n−1)−1).
- R6: With the default `CLEAR_NEG_ZERO` = 0, an all-ones result is passed through unchanged. For example, 8'h05 + 8'hFA gives 8'hFF with `carry_raw_o` = 0.
- R7: With `CLEAR_NEG_ZERO` = 1, an all-ones result becomes all zeros, and every other result is left unchanged.
- R8: Either zero encoding used as an operand acts as zero. For example, 8'h2A + 8'hFF gives 8'h2A.
- R9: For n = 4:
  - 4'b0100 + 4'b1100 yields 4'b0001 with `carry_raw_o` = 1;
  - 4'b1011 + 4'b1100 yields 4'b1000 with `carry_raw_o` = 1.
- R10: The end-around increment never produces a second carry out of the sign position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand, ones' complement |
| b_i | input | WIDTH | Second operand, ones' complement |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| sum_o | output | WIDTH | Corrected (and optionally zero-normalised) result |
| carry_raw_o | output | 1 | Carry out of the sign position from the first addition |
| ovf_o | output | 1 | Signed overflow indication |

## Verification
Because the block is purely combinational, a wrong internal signal shows at the ports in the same evaluation as the stimulus that exposes it. Nothing is hidden behind cycles of latency.

Each likely fault has a distinct signature at the ports:
- A lost or doubled end-around carry shows as a result off by exactly one, and only when `carry_raw_o` is 1.
- A wrong operand inversion flips the sign of the expected difference on every subtract.
- A broken zero rewrite shows only on all-ones results.

The bench therefore mixes directed carry and zero cases with a broad sweep of random operand pairs, and compares the numeric value of each result against integer arithmetic.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic {
    OC_ADD = 1'b0,
    OC_SUB = 1'b1
  } oc_op_e;
endpackage

// File: rtl/oc_operand_sel.sv
module oc_operand_sel
  import oc_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  oc_op_e           op_i,
  output logic [WIDTH-1:0] opnd_o
);
  // Negation in ones' complement is a plain bitwise inversion.
  always_comb begin
    opnd_o = (op_i == OC_SUB) ? ~opnd_i : opnd_i;
  end
endmodule

// File: rtl/oc_ripple_add.sv
module oc_ripple_add #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] s_o,
  output logic             cout_o
);
  logic [WIDTH:0] chain;

  assign chain[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_fa
    assign s_o[k]       = x_i[k] ^ y_i[k] ^ chain[k];
    assign chain[k + 1] = (x_i[k] & y_i[k]) | (chain[k] & (x_i[k] ^ y_i[k]));
  end

  assign cout_o = chain[WIDTH];
endmodule

// File: rtl/oc_negzero_fix.sv
module oc_negzero_fix #(
  parameter int unsigned WIDTH          = 8,
  parameter bit          CLEAR_NEG_ZERO = 1'b0
) (
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] val_o
);
  if (CLEAR_NEG_ZERO) begin : g_clear
    always_comb begin
      val_o = (&val_i) ? '0 : val_i;
    end
  end else begin : g_keep
    assign val_o = val_i;
  end

  always_comb begin
    if (CLEAR_NEG_ZERO) begin
      AST_NEGZERO_CLEARED: assert (!(&val_o)); // R7
      AST_OTHERS_UNTOUCHED: assert ((&val_i) || (val_o == val_i)); // R7
    end else begin
      AST_NEGZERO_KEPT: assert (val_o == val_i); // R6
    end
  end
endmodule

// File: rtl/oc_eac_adder.sv
module oc_eac_adder
  import oc_pkg::*;
#(
  parameter int unsigned WIDTH          = 8,
  parameter bit          CLEAR_NEG_ZERO = 1'b0
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_raw_o,
  output logic             ovf_o
);
  localparam int unsigned MSB = WIDTH - 1;

  oc_op_e           op;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] raw_sum;
  logic             raw_cout;
  logic [WIDTH-1:0] corr_sum;
  logic             inc_cout;

  assign op = oc_op_e'(sub_i);

  oc_operand_sel #(.WIDTH(WIDTH)) u_sel (
    .opnd_i (b_i),
    .op_i   (op),
    .opnd_o (b_eff)
  );

  // First pass: plain binary addition of the two operands.
  oc_ripple_add #(.WIDTH(WIDTH)) u_first (
    .x_i    (a_i),
    .y_i    (b_eff),
    .cin_i  (1'b0),
    .s_o    (raw_sum),
    .cout_o (raw_cout)
  );

  // Second pass: fold the sign-position carry back into the LSB.
  oc_ripple_add #(.WIDTH(WIDTH)) u_wrap (
    .x_i    (raw_sum),
    .y_i    ('0),
    .cin_i  (raw_cout),
    .s_o    (corr_sum),
    .cout_o (inc_cout)
  );

  oc_negzero_fix #(.WIDTH(WIDTH), .CLEAR_NEG_ZERO(CLEAR_NEG_ZERO)) u_zero (
    .val_i (corr_sum),
    .val_o (sum_o)
  );

  assign carry_raw_o = raw_cout;
  assign ovf_o       = (a_i[MSB] == b_eff[MSB]) && (corr_sum[MSB] != a_i[MSB]);

  logic [WIDTH:0] chk_wide;
  always_comb begin
    chk_wide = {1'b0, a_i} + {1'b0, b_eff};
    AST_WRAP_SUM: assert (corr_sum == WIDTH'(chk_wide[WIDTH-1:0] + WIDTH'(chk_wide[WIDTH]))); // R3
    AST_RAW_CARRY: assert (carry_raw_o == chk_wide[WIDTH]); // R4
    AST_OVF_SAME_SIGN: assert (!ovf_o || (a_i[MSB] == b_eff[MSB])); // R5
    AST_NO_SECOND_CARRY: assert (!inc_cout); // R10
  end
endmodule

// File: tb/tb_oc_eac_adder.sv
module tb_oc_eac_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] a_r = '0, b_r = '0;
  logic       sub_r = 1'b0;
  logic [7:0] sum_o, nsum_o;
  logic       cout_o, ncout_o, ovf_o, novf_o;
  logic [3:0] a4 = '0, b4 = '0, sum4;
  logic       sub4 = 1'b0, cout4, ovf4;

  oc_eac_adder #(.WIDTH(8), .CLEAR_NEG_ZERO(1'b0)) dut (
    .a_i(a_r), .b_i(b_r), .sub_i(sub_r),
    .sum_o(sum_o), .carry_raw_o(cout_o), .ovf_o(ovf_o));
  oc_eac_adder #(.WIDTH(8), .CLEAR_NEG_ZERO(1'b1)) dut_norm (
    .a_i(a_r), .b_i(b_r), .sub_i(sub_r),
    .sum_o(nsum_o), .carry_raw_o(ncout_o), .ovf_o(novf_o));
  oc_eac_adder #(.WIDTH(4)) dut_w4 (
    .a_i(a4), .b_i(b4), .sub_i(sub4),
    .sum_o(sum4), .carry_raw_o(cout4), .ovf_o(ovf4));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic       sub;
    int         val;
    bit         ovf;
    bit         cout;
    bit         exact;
    logic [7:0] sum;
    string      req;
  } exp_t;
  exp_t sb[$];

  function automatic int v8(input logic [7:0] x);
    logic [7:0] n;
    n = ~x;
    return x[7] ? -int'(n) : int'(x);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_op(input logic [7:0] a, input logic [7:0] b, input logic sub,
                         input bit exact, input logic [7:0] sum, input string req);
    exp_t e;
    logic [7:0] be;
    logic [8:0] w;
    @(posedge clk);
    #1;
    a_r = a; b_r = b; sub_r = sub;
    be = sub ? ~b : b;
    w  = {1'b0, a} + {1'b0, be};
    e.a = a; e.b = b; e.sub = sub;
    e.val = v8(a) + (sub ? -v8(b) : v8(b));
    e.ovf = (e.val > 127) || (e.val < -127);
    e.cout = w[8];
    e.exact = exact; e.sum = sum; e.req = req;
    sb.push_back(e);
  endtask

  // Monitor: compares each queued expectation in the cycle its inputs are applied.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(ovf_o == e.ovf, {e.req, " R5 ovf"}, int'(ovf_o), int'(e.ovf));
      chk(cout_o == e.cout, {e.req, " R4 carry"}, int'(cout_o), int'(e.cout));
      chk(novf_o == e.ovf, {e.req, " R7 norm ovf"}, int'(novf_o), int'(e.ovf));
      if (!e.ovf) begin
        chk(v8(sum_o) == e.val, {e.req, " value"}, v8(sum_o), e.val);
        chk(v8(nsum_o) == e.val, {e.req, " R7 norm value"}, v8(nsum_o), e.val);
        chk(nsum_o != 8'hFF, {e.req, " R7 no neg zero"}, int'(nsum_o), 0);
      end
      if (e.exact) chk(sum_o == e.sum, {e.req, " exact"}, int'(sum_o), int'(e.sum));
    end
  end

  task automatic check4(input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] s, input bit c);
    @(posedge clk);
    #1;
    a4 = a; b4 = b; sub4 = 1'b0;
    @(negedge clk);
    chk(sum4 == s, "R9 4-bit sum", int'(sum4), int'(s));
    chk(cout4 == c, "R9 4-bit carry", int'(cout4), int'(c));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sum_o == 8'h00, "R1 reset-state zero sum", int'(sum_o), 0);
    chk(ovf_o == 1'b0, "R5 reset-state no overflow", int'(ovf_o), 0);

    push_op(8'h05, 8'hFA, 1'b0, 1'b1, 8'hFF, "R6 neg zero kept");
    push_op(8'h05, 8'h05, 1'b1, 1'b1, 8'hFF, "R2 self subtract");
    push_op(8'h00, 8'hFF, 1'b1, 1'b1, 8'h00, "R2 zero minus neg zero");
    push_op(8'h2A, 8'hFF, 1'b0, 1'b1, 8'h2A, "R8 add neg zero");
    push_op(8'h2A, 8'h00, 1'b0, 1'b1, 8'h2A, "R8 add pos zero");
    push_op(8'h7F, 8'h01, 1'b0, 1'b0, 8'h00, "R5 positive overflow");
    push_op(8'h80, 8'hFE, 1'b0, 1'b0, 8'h00, "R5 negative overflow");
    push_op(8'h81, 8'hFE, 1'b0, 1'b1, 8'h80, "R3 wrap to -127");
    push_op(8'h10, 8'h20, 1'b1, 1'b1, 8'hEF, "R2 small difference");
    push_op(8'h40, 8'h3F, 1'b0, 1'b1, 8'h7F, "R1 top of range");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      push_op(ra, rb, 1'($urandom), 1'b0, 8'h00, (i % 2 == 0) ? "R1 sweep" : "R2 sweep");
    end
    while (sb.size() > 0) @(posedge clk);

    check4(4'b0100, 4'b1100, 4'b0001, 1'b1);
    check4(4'b1011, 4'b1100, 4'b1000, 1'b1);
    check4(4'b0011, 4'b0100, 4'b0111, 1'b0);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule